// File: doc/BRIEF.md
# Clock Measurement Counter Behind an Indexed Byte Window

This block gives a host byte-wide access to a frequency measurement counter through two small register windows, one for each of two channels. Each window has an index port and a data port. The host first writes an index byte to the index port. A later access to the data port then reaches the internal register that this index selects. The primary window holds a control byte. One bit of that byte starts and stops the counter.

The counter is a 30-bit down counter. It loses one count for each pulse on `meas_tick`, and it counts only while the run bit is set. `meas_tick` carries one pulse per rising edge of the clock under measurement, already brought into the host clock domain. Software starts the counter, waits a known time and stops it. The difference between the two counts gives the frequency. The count is read as four bytes: two through the primary window and two through the secondary window. Byte reads come straight from the live counter, with no snapshot. Because of this, a read that runs while the upper bits change can return a torn value, and software has to re-read and compare.

Top module: `ixc_clkmeas_window`

## Requirements
- R1: After reset the counter holds the parameter `RST_VAL` (all ones by default). The control byte reads 0x00 and both index ports read 0x00.
- R2: The byte address is 4 bits wide. The primary index port is at address 1 and the secondary index port is at address 9. Writing either one stores the byte, and reading it returns the stored byte.
- R3: When the primary index is 0x01, the primary data port (address 3) reads and writes the control byte. All 8 bits are stored as written and read back unchanged.
- R4: While control bit 6 (mask 0x40) is 1, the counter drops by one at each clock edge where `meas_tick` is 1. When bit 6 is 0 or `meas_tick` is 0, the counter holds its value.
- R5: The counter wraps from 0 to 2^30-1.
- R6: Reading the primary data port returns count bits 7:0 when the primary index is 0x20. When the primary index is 0x21, it returns count bits 14:8 with bit 7 of the byte at 0.
- R7: Reading the secondary data port (address 11) returns count bits 22:15 when the secondary index is 0x20. When the secondary index is 0x21, it returns count bits 29:23 with bit 7 of the byte at 0.
- R8: Writes to the count bytes are ignored, and the count is left unchanged.
- R9: Any other index on either data port reads 0x00, and writes to it are ignored. This includes index 0x01 on the secondary window. Addresses other than 1, 3, 9 and 11 read 0x00.
- R10: Data port reads are combinational. In a cycle with a counting pulse, the read shows the count from before that edge. A control write and a counting pulse in the same cycle still count once, because the old run bit applies at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address within the two windows |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| meas_tick | input | 1 | One pulse per edge of the measured clock |

## Verification
A counting pulse can fall in the same cycle as a byte read, and also in the same cycle as the write that clears the run bit. The bench drives `meas_tick` together with a data-port read. It expects the byte from before the edge, and it expects the decremented byte on the next read. It also issues the stopping control write with a pulse in the same cycle and expects exactly one more decrement. A small reset value makes the counter wrap within a few pulses, so the upper bytes can be checked as they change all at once.

// File: rtl/ixc_pkg.sv
package ixc_pkg;
   localparam int unsigned N_CHAN = 2;
   localparam logic [7:0] CTRL_IDX = 8'h01;
   localparam logic [7:0] CNT_LO_IDX = 8'h20;
   localparam logic [7:0] CNT_HI_IDX = 8'h21;
   localparam int unsigned LO_SPLIT = 15;
   localparam int unsigned HI_SPLIT = 23;
endpackage

// File: rtl/ixc_index_reg.sv
module ixc_index_reg #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] idx
);
   always_ff @(posedge clk) begin
      if (!rst_n) idx <= '0;
      else if (load) idx <= wdata;
   end

   // R2
   idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(idx));
endmodule

// File: rtl/ixc_meas_counter.sv
module ixc_meas_counter #(
   parameter int unsigned CNT_W = 30,
   parameter logic [CNT_W-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= RST_VAL;
      else if (run && tick) cnt <= cnt - 1'b1;
   end

   // R4
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && tick) |=> $stable(cnt));
   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/ixc_read_mux.sv
module ixc_read_mux
   import ixc_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W = 30,
   parameter int unsigned CHAN_STRIDE = 8,
   parameter int unsigned IDX_OFS = 1,
   parameter int unsigned DAT_OFS = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        pri_idx,
   input  logic [7:0]        sec_idx,
   input  logic [7:0]        ctrl,
   input  logic [CNT_W-1:0]  cnt,
   output logic [7:0]        rdata
);
   localparam logic [ADDR_W-1:0] PRI_IDX_A = ADDR_W'(IDX_OFS);
   localparam logic [ADDR_W-1:0] SEC_IDX_A = ADDR_W'(CHAN_STRIDE + IDX_OFS);
   localparam logic [ADDR_W-1:0] PRI_DAT_A = ADDR_W'(DAT_OFS);
   localparam logic [ADDR_W-1:0] SEC_DAT_A = ADDR_W'(CHAN_STRIDE + DAT_OFS);

   logic [7:0] byte0, byte1, byte2, byte3;
   assign byte0 = cnt[7:0];
   assign byte1 = 8'(cnt[LO_SPLIT-1:8]);
   assign byte2 = cnt[HI_SPLIT-1:LO_SPLIT];
   assign byte3 = 8'(cnt[CNT_W-1:HI_SPLIT]);

   always_comb begin
      rdata = '0;
      if (addr == PRI_IDX_A) rdata = pri_idx;
      else if (addr == SEC_IDX_A) rdata = sec_idx;
      else if (addr == PRI_DAT_A) begin
         case (pri_idx)
            CTRL_IDX:   rdata = ctrl;
            CNT_LO_IDX: rdata = byte0;
            CNT_HI_IDX: rdata = byte1;
            default:    rdata = '0;
         endcase
      end else if (addr == SEC_DAT_A) begin
         case (sec_idx)
            CNT_LO_IDX: rdata = byte2;
            CNT_HI_IDX: rdata = byte3;
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ixc_clkmeas_window.sv
module ixc_clkmeas_window
   import ixc_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned CNT_W = 30,
   parameter logic [CNT_W-1:0] RST_VAL = '1,
   parameter int unsigned CHAN_STRIDE = 8,
   parameter int unsigned IDX_OFS = 1,
   parameter int unsigned DAT_OFS = 3,
   parameter int unsigned RUN_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              meas_tick
);
   localparam logic [ADDR_W-1:0] PRI_DAT_A = ADDR_W'(DAT_OFS);

   if (CNT_W <= HI_SPLIT || CNT_W > HI_SPLIT + 7) begin : g_bad_cnt_w
      $error("CNT_W must fit the four-byte read map");
   end
   if (RUN_BIT > 7) begin : g_bad_run_bit
      $error("RUN_BIT must lie within the control byte");
   end
   if ((2 * CHAN_STRIDE) > (1 << ADDR_W) || IDX_OFS == DAT_OFS ||
       IDX_OFS >= CHAN_STRIDE || DAT_OFS >= CHAN_STRIDE) begin : g_bad_map
      $error("window offsets do not fit the address space");
   end

   logic [7:0] idx_q [N_CHAN];
   logic [7:0] ctrl_q;
   logic [CNT_W-1:0] cnt_q;
   logic ctrl_we;

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      logic hit;
      assign hit = bus_wr && (bus_addr == ADDR_W'(c * CHAN_STRIDE + IDX_OFS));
      ixc_index_reg #(.DW(8)) u_idx (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (hit),
         .wdata (bus_wdata),
         .idx   (idx_q[c])
      );
   end

   assign ctrl_we = bus_wr && (bus_addr == PRI_DAT_A) && (idx_q[0] == CTRL_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= bus_wdata;
   end

   ixc_meas_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q[RUN_BIT]),
      .tick  (meas_tick),
      .cnt   (cnt_q)
   );

   ixc_read_mux #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CHAN_STRIDE(CHAN_STRIDE),
      .IDX_OFS(IDX_OFS), .DAT_OFS(DAT_OFS)
   ) u_rmux (
      .addr    (bus_addr),
      .pri_idx (idx_q[0]),
      .sec_idx (idx_q[1]),
      .ctrl    (ctrl_q),
      .cnt     (cnt_q),
      .rdata   (bus_rdata)
   );

   // R3
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == PRI_DAT_A && idx_q[0] == CTRL_IDX) |=> $stable(ctrl_q));
   // R9
   unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == PRI_DAT_A && idx_q[0] != CTRL_IDX && idx_q[0] != CNT_LO_IDX &&
       idx_q[0] != CNT_HI_IDX) |-> (bus_rdata == 8'h00));
   // R8
   cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !meas_tick) |=> $stable(cnt_q));
endmodule

// File: tb/ixc_clkmeas_window_tb.sv
module ixc_clkmeas_window_tb_top;
   localparam int CLK_P = 10;
   localparam logic [29:0] TB_RST = 30'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic meas_tick = 1'b0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ixc_clkmeas_window #(.RST_VAL(TB_RST)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .meas_tick(meas_tick)
   );

   // model of the register window, from the requirements
   logic [29:0] m_cnt;
   logic [7:0] m_ctrl, m_idx0, m_idx1;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= TB_RST; m_ctrl <= '0; m_idx0 <= '0; m_idx1 <= '0;
      end else begin
         if (m_ctrl[6] && meas_tick) m_cnt <= m_cnt - 30'd1;
         if (bus_wr) begin
            if (bus_addr == 4'd1) m_idx0 <= bus_wdata;
            if (bus_addr == 4'd9) m_idx1 <= bus_wdata;
            if (bus_addr == 4'd3 && m_idx0 == 8'h01) m_ctrl <= bus_wdata;
         end
      end
   end

   function automatic logic [7:0] model_byte(input logic [3:0] a);
      logic [7:0] v;
      v = 8'h00;
      if (a == 4'd1) v = m_idx0;
      else if (a == 4'd9) v = m_idx1;
      else if (a == 4'd3) begin
         if (m_idx0 == 8'h01) v = m_ctrl;
         else if (m_idx0 == 8'h20) v = m_cnt[7:0];
         else if (m_idx0 == 8'h21) v = {1'b0, m_cnt[14:8]};
      end else if (a == 4'd11) begin
         if (m_idx1 == 8'h20) v = m_cnt[22:15];
         else if (m_idx1 == 8'h21) v = {1'b0, m_cnt[29:23]};
      end
      return v;
   endfunction

   // scoreboard
   logic [7:0] exp_q[$];
   string tag_q[$];
   event mon_ev;

   always @(mon_ev) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata !== e) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
      end
   end

   task automatic rd(input logic [3:0] a, input string tag, input bit tk = 0,
                     input bit lit_en = 0, input logic [7:0] lit = 8'h00);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0; meas_tick = tk;
      #2;
      exp_q.push_back(lit_en ? lit : model_byte(a));
      tag_q.push_back(tag);
      ->mon_ev;
      @(negedge clk);
      meas_tick = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input bit tk = 0);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d; meas_tick = tk;
      @(negedge clk);
      bus_wr = 1'b0; meas_tick = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); meas_tick = 1'b1;
         @(negedge clk); meas_tick = 1'b0;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(4'd1, "R1 primary index", 0, 1, 8'h00);
      rd(4'd9, "R1 secondary index", 0, 1, 8'h00);
      rd(4'd3, "R1 data at index 0", 0, 1, 8'h00);
      wr(4'd1, 8'h01);
      rd(4'd3, "R1 ctrl reset", 0, 1, 8'h00);
      // R2 index readback
      rd(4'd1, "R2 primary index", 0, 1, 8'h01);
      wr(4'd9, 8'h21);
      rd(4'd9, "R2 secondary index", 0, 1, 8'h21);
      rd(4'd11, "R7 reset top byte", 0, 1, 8'h00);
      // R3 control byte
      wr(4'd3, 8'hBE);
      rd(4'd3, "R3 ctrl readback", 0, 1, 8'hBE);
      wr(4'd3, 8'h41);
      rd(4'd3, "R3 ctrl run set", 0, 1, 8'h41);
      // R4/R6/R10 counting with live reads
      wr(4'd1, 8'h20);
      rd(4'd3, "R6 low byte before", 0, 1, 8'h03);
      rd(4'd3, "R10 read in tick cycle", 1, 1, 8'h03);
      rd(4'd3, "R4 after one tick", 0, 1, 8'h02);
      pulse(2);
      rd(4'd3, "R4 low byte zero", 0, 1, 8'h00);
      // R5 wrap
      rd(4'd3, "R10 read at wrap edge", 1, 1, 8'h00);
      rd(4'd3, "R5 low byte after wrap", 0, 1, 8'hFF);
      wr(4'd1, 8'h21);
      rd(4'd3, "R6 byte1 after wrap", 0, 1, 8'h7F);
      wr(4'd9, 8'h20);
      rd(4'd11, "R7 byte2 after wrap", 0, 1, 8'hFF);
      wr(4'd9, 8'h21);
      rd(4'd11, "R7 byte3 after wrap", 0, 1, 8'h7F);
      pulse(5);
      wr(4'd1, 8'h20);
      rd(4'd3, "R4 model low byte", 0, 0);
      rd(4'd11, "R7 model byte3", 0, 0);
      // R10 stop write with tick in same cycle: one count more
      wr(4'd1, 8'h01);
      wr(4'd3, 8'h01, 1);
      wr(4'd1, 8'h20);
      rd(4'd3, "R10 stop with tick", 0, 1, 8'hF9);
      pulse(3);
      rd(4'd3, "R4 hold while stopped", 0, 1, 8'hF9);
      // R8 count bytes read-only
      wr(4'd3, 8'h00);
      rd(4'd3, "R8 low byte write ignored", 0, 1, 8'hF9);
      wr(4'd9, 8'h20);
      wr(4'd11, 8'h12);
      rd(4'd11, "R8 byte2 write ignored", 0, 1, 8'hFF);
      // R9 unimplemented indices and offsets
      wr(4'd1, 8'h05);
      wr(4'd3, 8'hAA);
      rd(4'd3, "R9 primary index 05", 0, 1, 8'h00);
      wr(4'd9, 8'h01);
      wr(4'd11, 8'h40);
      rd(4'd11, "R9 secondary index 01", 0, 1, 8'h00);
      wr(4'd1, 8'h01);
      rd(4'd3, "R9 ctrl untouched", 0, 1, 8'h01);
      pulse(2);
      wr(4'd1, 8'h20);
      rd(4'd3, "R9 counter still held", 0, 1, 8'hF9);
      rd(4'd0, "R9 offset 0", 0, 1, 8'h00);
      rd(4'd2, "R9 offset 2", 0, 1, 8'h00);
      rd(4'd15, "R9 offset 15", 0, 1, 8'h00);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule